// File: doc/BRIEF.md
# Single-Bus Accumulator Add Sequencer

This block is the datapath and control sequencer of a small processor built around one internal bus. It holds a program counter, an address-field instruction register, a memory address register, a memory buffer register and an accumulator. The ALU has an input latch (Y) and an output latch (Z). An instruction word holds a two-bit mode and an address field. When `start` is accepted, the sequencer runs one bus transfer per clock step and finishes the chosen operation: it adds an immediate, direct or indirect operand into the accumulator, or it increments the program counter through the ALU.

In every step exactly one source drives the bus. The register chosen as destination copies the bus value at the end of the step. Memory is a word array with a synchronous write port for preloading and a read path that settles within the step. A timing model gives the minimum step length for the step now in progress: a plain register-to-register transfer needs bus propagation plus copy time, and a step through the ALU also needs ALU propagation.

Top module: `sbus_add_seq`

## Requirements
- R1: After reset, `ac`, `pc`, `busy`, `done` and `step_ns` are all zero.
- R2: Mode 2'b00 (immediate) takes 3 steps and adds the zero-extended address field `instr[AW-1:0]` into the accumulator.
- R3: Mode 2'b01 (direct) takes 5 steps and adds the memory word at the address field into the accumulator.
- R4: Mode 2'b10 (indirect) takes 7 steps. It reads the word at the address field, uses the low AW bits of that word as a second address, and adds the word stored there.
- R5: Mode 2'b11 takes 2 steps and increments `pc` by one through Z, leaving the accumulator unchanged.
- R6: While `busy`, exactly one bus source is enabled and at least one register load is enabled in every step.
- R7: `step_ns` is BUS_NS+COPY_NS (30) for a transfer step and BUS_NS+ALU_NS+COPY_NS (130) for the ALU step. Over a whole operation the steps sum to 190, 250, 310 and 160 for immediate, direct, indirect and increment.
- R8: `busy` is high for exactly the operation's step count. `done` is high only in the last step. The results are visible on `ac`/`pc` in the cycle after `done`.
- R9: A `start` while `busy` is ignored and does not change the running operation or its result.
- R10: Accumulator sums wrap modulo 2^DW.
- R11: When `mem_we` is high, `mem_wdata` is written at `mem_waddr` on the clock edge. Later reads of that address return it within the step that loads the buffer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr | input | AW+2 | {mode[1:0], address field[AW-1:0]} |
| mem_we | input | 1 | Memory preload write enable |
| mem_waddr | input | AW | Memory preload address |
| mem_wdata | input | DW | Memory preload data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final step of the operation |
| step_ns | output | NS_W | Minimum time for the current step, ns |
| ac | output | DW | Accumulator |
| pc | output | DW | Program counter |

## Verification
The bench builds the block with DW=12 and AW=6. The small data width makes accumulator wrap-around happen after a few additions. The 64-word memory can be preloaded completely, so every address, including the top one, can be used as an operand or as a pointer. Memory words are wider than the address, so indirect pointers whose upper bits must be dropped come up naturally.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [1:0] {
    M_IMM = 2'd0,
    M_DIR = 2'd1,
    M_IND = 2'd2,
    M_PCI = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ALU_NONE = 2'd0,
    ALU_ADDY = 2'd1,
    ALU_INC1 = 2'd2
  } alu_e;

  localparam int STEP_W = 3;
  localparam int NDRV   = 6;
  localparam int NLD    = 6;

  // bus driver indices
  localparam int D_PC  = 0;
  localparam int D_IRA = 1;
  localparam int D_MBR = 2;
  localparam int D_Z   = 3;
  localparam int D_AC  = 4;
  localparam int D_MEM = 5;

  // register load indices
  localparam int L_PC  = 0;
  localparam int L_MAR = 1;
  localparam int L_MBR = 2;
  localparam int L_Y   = 3;
  localparam int L_Z   = 4;
  localparam int L_AC  = 5;

  typedef struct packed {
    logic [NDRV-1:0] drv;
    logic [NLD-1:0]  ld;
    alu_e            alu;
  } ctl_t;

  function automatic logic [STEP_W-1:0] seq_len(mode_e m);
    case (m)
      M_IMM:   return 3'd3;
      M_DIR:   return 3'd5;
      M_IND:   return 3'd7;
      default: return 3'd2;
    endcase
  endfunction

  // Control word for step s of mode m. Add modes share a three-step tail,
  // so the tail is picked by distance from the end of the sequence.
  function automatic ctl_t step_ctl(mode_e m, logic [STEP_W-1:0] s);
    ctl_t c;
    logic [STEP_W-1:0] k;
    c = '0;
    c.alu = ALU_NONE;
    k = seq_len(m) - 3'd1 - s;
    if (m == M_PCI) begin
      if (s == 3'd0) begin
        c.drv[D_PC] = 1'b1; c.ld[L_Z] = 1'b1; c.alu = ALU_INC1;
      end else begin
        c.drv[D_Z] = 1'b1; c.ld[L_PC] = 1'b1;
      end
    end else if (k == 3'd0) begin
      c.drv[D_Z] = 1'b1; c.ld[L_AC] = 1'b1;
    end else if (k == 3'd1) begin
      c.drv[D_AC] = 1'b1; c.ld[L_Z] = 1'b1; c.alu = ALU_ADDY;
    end else if (k == 3'd2) begin
      c.ld[L_Y] = 1'b1;
      if (m == M_IMM) c.drv[D_IRA] = 1'b1;
      else            c.drv[D_MBR] = 1'b1;
    end else begin
      case (s)
        3'd0: begin c.drv[D_IRA] = 1'b1; c.ld[L_MAR] = 1'b1; end
        3'd1,
        3'd3: begin c.drv[D_MEM] = 1'b1; c.ld[L_MBR] = 1'b1; end
        default: begin c.drv[D_MBR] = 1'b1; c.ld[L_MAR] = 1'b1; end
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
  import sbus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  mode_e mode,
  output ctl_t  ctl,
  output logic  busy,
  output logic  done
);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  mode_e             mode_q;
  logic              accept;
  logic              last_step;

  assign accept    = start && !busy_q;
  assign last_step = busy_q && (step_q == seq_len(mode_q) - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      mode_q <= M_IMM;
    end else if (accept) begin
      busy_q <= 1'b1;
      step_q <= '0;
      mode_q <= mode;
    end else if (busy_q) begin
      if (last_step) busy_q <= 1'b0;
      else           step_q <= step_q + 3'd1;
    end
  end

  always_comb begin
    ctl = '0;
    ctl.alu = ALU_NONE;
    if (busy_q) ctl = step_ctl(mode_q, step_q);
  end

  assign busy = busy_q;
  assign done = last_step;

  // R8: the step counter never runs past the sequence length
  p_step_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q < seq_len(mode_q)));

  // R8: after the final step the sequencer is idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !busy_q);

endmodule

// File: rtl/sbus_timing.sv
module sbus_timing
  import sbus_pkg::*;
#(
  parameter int BUS_NS  = 20,
  parameter int ALU_NS  = 100,
  parameter int COPY_NS = 10,
  parameter int NS_W    = 8
) (
  input  logic            active,
  input  alu_e            alu,
  output logic [NS_W-1:0] step_ns
);

  localparam int T_MOVE = BUS_NS + COPY_NS;
  localparam int T_ALU  = BUS_NS + ALU_NS + COPY_NS;

  function automatic logic [NS_W-1:0] budget(logic act, alu_e op);
    if (!act)              return '0;
    else if (op != ALU_NONE) return NS_W'(T_ALU);
    else                   return NS_W'(T_MOVE);
  endfunction

  assign step_ns = budget(active, alu);

endmodule

// File: rtl/sbus_mem.sv
module sbus_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sbus_add_seq.sv
module sbus_add_seq
  import sbus_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int BUS_NS  = 20,
  parameter int ALU_NS  = 100,
  parameter int COPY_NS = 10,
  parameter int NS_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW+1:0]   instr,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_waddr,
  input  logic [DW-1:0]   mem_wdata,
  output logic            busy,
  output logic            done,
  output logic [NS_W-1:0] step_ns,
  output logic [DW-1:0]   ac,
  output logic [DW-1:0]   pc
);

  localparam int PAD = DW - AW;

  ctl_t          ctl;
  logic          seq_busy;
  logic          seq_done;
  mode_e         in_mode;
  logic [AW-1:0] ir_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] pc_q, mbr_q, ac_q, y_q, z_q;
  logic [DW-1:0] mem_rd;
  logic [DW-1:0] bus;
  logic [DW-1:0] alu_y;
  logic          take_start;

  assign in_mode    = mode_e'(instr[AW+1:AW]);
  assign take_start = start && !seq_busy;

  sbus_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .mode  (in_mode),
    .ctl   (ctl),
    .busy  (seq_busy),
    .done  (seq_done)
  );

  sbus_timing #(
    .BUS_NS (BUS_NS),
    .ALU_NS (ALU_NS),
    .COPY_NS(COPY_NS),
    .NS_W   (NS_W)
  ) u_tim (
    .active (seq_busy),
    .alu    (ctl.alu),
    .step_ns(step_ns)
  );

  sbus_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(mar_q),
    .rdata(mem_rd)
  );

  // single shared bus: OR of gated sources, exactly one enabled per step
  always_comb begin
    bus = '0;
    if (ctl.drv[D_PC])  bus = bus | pc_q;
    if (ctl.drv[D_IRA]) bus = bus | {{PAD{1'b0}}, ir_q};
    if (ctl.drv[D_MBR]) bus = bus | mbr_q;
    if (ctl.drv[D_Z])   bus = bus | z_q;
    if (ctl.drv[D_AC])  bus = bus | ac_q;
    if (ctl.drv[D_MEM]) bus = bus | mem_rd;
  end

  function automatic logic [DW-1:0] alu_calc(alu_e op, logic [DW-1:0] b,
                                             logic [DW-1:0] y);
    case (op)
      ALU_ADDY: return b + y;
      ALU_INC1: return b + DW'(1);
      default:  return b;
    endcase
  endfunction

  assign alu_y = alu_calc(ctl.alu, bus, y_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q  <= '0;
      mar_q <= '0;
      pc_q  <= '0;
      mbr_q <= '0;
      ac_q  <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      if (take_start)     ir_q  <= instr[AW-1:0];
      if (ctl.ld[L_MAR])  mar_q <= bus[AW-1:0];
      if (ctl.ld[L_PC])   pc_q  <= bus;
      if (ctl.ld[L_MBR])  mbr_q <= bus;
      if (ctl.ld[L_AC])   ac_q  <= bus;
      if (ctl.ld[L_Y])    y_q   <= bus;
      if (ctl.ld[L_Z])    z_q   <= alu_y;
    end
  end

  assign busy = seq_busy;
  assign done = seq_done;
  assign ac   = ac_q;
  assign pc   = pc_q;

  // R6: exactly one bus source per active step
  p_one_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> ($countones(ctl.drv) == 1));

  // R6: every active step loads something
  p_some_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (ctl.ld != '0));

  // R7: the step that loads Z through the ALU gets the long budget
  p_alu_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && ctl.ld[L_Z]) |-> (step_ns == NS_W'(BUS_NS + ALU_NS + COPY_NS)));

  // R7: steps loading other registers get the short budget
  p_move_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !ctl.ld[L_Z]) |-> (step_ns == NS_W'(BUS_NS + COPY_NS)));

  // R8: done only inside a running sequence
  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> seq_busy);

  // R5: the accumulator only moves on its own load step
  p_ac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ld[L_AC] |=> $stable(ac_q));

  // R9: a start while busy leaves the instruction register alone
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && start) |=> $stable(ir_q));

endmodule

// File: tb/sbus_add_seq_test.sv
module sbus_add_seq_test;

  localparam int DW   = 12;
  localparam int AW   = 6;
  localparam int NS_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [AW+1:0]   instr;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [DW-1:0]   mem_wdata;
  logic            busy, done;
  logic [NS_W-1:0] step_ns;
  logic [DW-1:0]   ac, pc;

  always #4 clk = ~clk;  // 125 MHz

  sbus_add_seq #(.DW(DW), .AW(AW), .NS_W(NS_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .step_ns(step_ns), .ac(ac), .pc(pc)
  );

  typedef struct {
    int            steps;
    int            ns;
    logic [DW-1:0] ac;
    logic [DW-1:0] pc;
    string         tag;
  } exp_t;

  exp_t          q[$];
  int            n_cmp = 0;
  int            n_bad = 0;
  logic [DW-1:0] ac_m = '0;
  logic [DW-1:0] pc_m = '0;
  logic [DW-1:0] mem_m [64];
  logic          all_done = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R11: preload port
  task automatic write_mem(int a, logic [DW-1:0] d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = a[AW-1:0]; mem_wdata = d;
    mem_m[a] = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  // driver: computes the expected outcome and pushes it to the scoreboard
  task automatic run(int mode, int addr, bit poke, string extra);
    exp_t          e;
    logic [DW:0]   sum;
    logic [DW-1:0] opnd;
    opnd = '0;
    case (mode)
      0: begin opnd = DW'(addr); e.steps = 3; e.tag = "R2 R6 immediate"; end
      1: begin opnd = mem_m[addr]; e.steps = 5; e.tag = "R3 R6 direct"; end
      2: begin opnd = mem_m[int'(mem_m[addr][AW-1:0])]; e.steps = 7;
               e.tag = "R4 R6 indirect"; end
      default: begin e.steps = 2; e.tag = "R5 increment"; end
    endcase
    if (mode != 3) begin
      sum = {1'b0, ac_m} + {1'b0, opnd};
      if (sum[DW]) e.tag = {e.tag, " R10 wrap"};
      ac_m = sum[DW-1:0];
    end else begin
      pc_m = pc_m + DW'(1);
    end
    e.tag = {e.tag, extra};
    // R7: every operation has exactly one ALU step (130) and the rest 30
    e.ns = (e.steps - 1) * 30 + 130;
    e.ac = ac_m;
    e.pc = pc_m;
    q.push_back(e);
    @(negedge clk);
    start = 1'b1;
    instr = {mode[1:0], addr[AW-1:0]};
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      instr = {2'b00, 6'd63};
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (busy);
  endtask

  // monitor: counts steps and budget, compares results the cycle after done
  initial begin
    int cnt = 0;
    int ns  = 0;
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " ac"}, ac, e.ac);
        chk({e.tag, " pc"}, pc, e.pc);
        pend = 1'b0;
      end
      if (done && !busy) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 done outside busy: actual=1 expected=0");
      end
      if (busy) begin
        cnt++;
        ns += int'(step_ns);
        if (done) begin
          chk({"R8 step count ", q[0].tag}, cnt, q[0].steps);
          chk({"R7 time budget ", q[0].tag}, ns, q[0].ns);
          cnt = 0; ns = 0; pend = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      n_cmp++; n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0;
    mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 ac", ac, 0);
    chk("R1 pc", pc, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 step_ns", step_ns, 0);

    for (int i = 0; i < 64; i++) write_mem(i, DW'(i * 1571 + 11));

    run(0, 5, 1'b0, "");
    run(0, 63, 1'b0, "");
    run(1, 0, 1'b0, "");
    run(1, 63, 1'b0, "");
    run(2, 7, 1'b0, "");
    run(2, 40, 1'b1, " R9 poke");
    run(3, 0, 1'b0, "");
    run(3, 0, 1'b0, "");
    run(3, 0, 1'b1, " R9 poke");
    write_mem(9, 12'hABC);
    run(1, 9, 1'b0, " R11 rewrite");
    run(2, 9, 1'b0, " R11 rewrite");
    for (int k = 0; k < 16; k++) run(k % 4, (k * 13 + 3) % 64, k == 5, "");

    repeat (4) @(negedge clk);
    all_done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule